// File: doc/BRIEF.md
# Processor bus error checker

This block sits beside the processor bus and inspects every transaction that is offered to it. It flags two processor-side faults: transactions the system cannot carry out, and writes into the boot ROM/Flash window that the current write policy forbids. Faults are recorded in two sticky error registers. The address of the first fault is latched. The data tenure of a faulting transaction is ended with an internal acknowledge. Software clears the recorded faults by writing ones to the flags it wants to drop.

Two kinds of transaction are unsupported. The first is a write into the interrupt-acknowledge space, whose location depends on a run-time address map select. The second is the external-control graphics transfer type. A write to the ROM window is legal only when Flash writes are enabled and not locked out. The policy does not depend on the size of the write, so the block has no size input. A non-maskable interrupt input is passed on to a machine-check output. Any pending error flag holds that output low, and the interrupt itself is never recorded.

Top module: `cpu_bus_err_chk`

## Requirements
- R1: With `map_sel`=0, a write (`txn_write`=1) to 0xBFFF_FFF0..0xBFFF_FFFF sets `err1` bit 0. A read of the same range, or a write to the map-1 range, does not.
- R2: With `map_sel`=1, a write to 0xFEF0_0000..0xFEFF_FFFF sets `err1` bit 0. A read of that range, or a write to the map-0 range, does not.
- R3: A transaction with `txn_ext_ctl`=1 sets `err1` bit 1, whether it is a read or a write.
- R4: A write to 0xFFF0_0000..0xFFFF_FFFF sets `err2` bit 0 unless `flash_wr_en`=1 and `flash_wr_lock`=0. Reads of the window never set it.
- R5: The flags `err1[1:0]` and `err2[0]` are sticky. When `clr_valid`=1, each flag whose bit is 1 in `clr_type` or `clr_flash` is cleared. A detection in the same cycle wins over the clear.
- R6: `err1` bit 3 and `err2` bit 7 read 1 after reset. Both read 0 from the cycle after any error is detected. Both return to 1 once no flag is pending. All other bits of `err1` and `err2` read 0.
- R7: `err_addr` resets to 0. It captures the transaction address of an error detected while no flag is pending, and holds its value otherwise.
- R8: `int_ack` is a one-cycle pulse in the cycle after an error is detected, provided `ack_suppress`=0. It is never high otherwise.
- R9: `mcp_out` equals `nmi_in` AND `mcp_en` AND no flag pending. `nmi_in` never changes any error flag.
- R10: Registered outputs change on the clock edge that samples `txn_valid`=1, which gives one cycle of latency. Inputs with `txn_valid`=0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| txn_valid | input | 1 | A transaction is presented this cycle |
| txn_addr | input | 32 | Transaction address |
| txn_write | input | 1 | 1 = write, 0 = read |
| txn_ext_ctl | input | 1 | External-control graphics transfer type |
| map_sel | input | 1 | Address map select (0 or 1) |
| flash_wr_en | input | 1 | Flash write enable |
| flash_wr_lock | input | 1 | Flash write lockout |
| ack_suppress | input | 1 | 1 = no internal acknowledge on error |
| clr_valid | input | 1 | Write-one-to-clear access strobe |
| clr_type | input | 2 | Clear mask for `err1[1:0]` |
| clr_flash | input | 1 | Clear mask for `err2[0]` |
| nmi_in | input | 1 | Non-maskable interrupt input |
| mcp_en | input | 1 | Machine-check reporting enable |
| err1 | output | 8 | Error register 1: [1:0] fault type, [3] source marker |
| err2 | output | 8 | Error register 2: [0] Flash fault, [7] source marker |
| err_addr | output | 32 | Latched fault address |
| int_ack | output | 1 | Internal transfer acknowledge pulse |
| mcp_out | output | 1 | Machine-check output |

## Verification
The embedded assertions run on every cycle. They check that an acknowledge only follows a detected fault with suppression off, that flags stay set unless cleared, that the latched address stays frozen while a fault is pending, and that the source markers drop after every fault. Other behaviour is visible only through the bench's scenarios, which the behavioural reference model scores on every clock. This covers the exact address ranges per map, the exemption of reads, the Flash enable/lockout combinations, clear-versus-detect ordering, and the masking of the machine-check output by pending flags.

// File: rtl/cbe_pkg.sv
// Package: shared widths and the decode result type for the processor bus
// error checker. Assumes a 32-bit processor address bus.
package cbe_pkg;
    localparam int ADDR_W = 32;
    localparam int REG_W  = 8;

    // One bit per fault kind, each already qualified by the transaction strobe.
    typedef struct packed {
        logic ia_wr;     // write into interrupt-acknowledge space
        logic ext_ctl;   // external-control graphics transfer
        logic flash_wr;  // forbidden write into the ROM window
    } cbe_hits_t;
endpackage

// File: rtl/cbe_decode.sv
// Module: cbe_decode
// Classifies one presented transaction into fault kinds. The logic is purely
// combinational. Windows are given as base/mask pairs, and a window hits when
// (addr & mask) == base. The interrupt-acknowledge window is picked at run time
// by map_sel. Assumes every base has no bits outside its mask.
module cbe_decode #(
    parameter int          AW        = cbe_pkg::ADDR_W,
    parameter logic [31:0] IA0_BASE  = 32'hBFFF_FFF0,
    parameter logic [31:0] IA0_MASK  = 32'hFFFF_FFF0,
    parameter logic [31:0] IA1_BASE  = 32'hFEF0_0000,
    parameter logic [31:0] IA1_MASK  = 32'hFFF0_0000,
    parameter logic [31:0] ROM_BASE  = 32'hFFF0_0000,
    parameter logic [31:0] ROM_MASK  = 32'hFFF0_0000
) (
    input  logic              valid,
    input  logic [AW-1:0]     addr,
    input  logic              write,
    input  logic              ext_ctl,
    input  logic              map_sel,
    input  logic              wr_en,
    input  logic              wr_lock,
    output cbe_pkg::cbe_hits_t hits
);
    localparam logic [AW-1:0] IA0_B = IA0_BASE[AW-1:0];
    localparam logic [AW-1:0] IA0_M = IA0_MASK[AW-1:0];
    localparam logic [AW-1:0] IA1_B = IA1_BASE[AW-1:0];
    localparam logic [AW-1:0] IA1_M = IA1_MASK[AW-1:0];
    localparam logic [AW-1:0] ROM_B = ROM_BASE[AW-1:0];
    localparam logic [AW-1:0] ROM_M = ROM_MASK[AW-1:0];

    logic in_ia0, in_ia1, in_rom, flash_ok;

    // Window matching and fault classification for the current transaction.
    always_comb begin
        in_ia0   = (addr & IA0_M) == IA0_B;
        in_ia1   = (addr & IA1_M) == IA1_B;
        in_rom   = (addr & ROM_M) == ROM_B;
        flash_ok = wr_en && !wr_lock;
        hits.ia_wr    = valid && write && (map_sel ? in_ia1 : in_ia0);
        hits.ext_ctl  = valid && ext_ctl;
        hits.flash_wr = valid && write && in_rom && !flash_ok;
    end
endmodule

// File: rtl/cbe_err_regs.sv
// Module: cbe_err_regs
// Holds the sticky fault flags, the source marker, the fault address latch and
// the acknowledge pulse. Flags clear through a write-one-to-clear strobe, and a
// fresh detection overrides a clear in the same cycle. The address is taken
// only when no flag is pending before the edge.
module cbe_err_regs #(
    parameter int AW = cbe_pkg::ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  cbe_pkg::cbe_hits_t hits,
    input  logic [AW-1:0]      addr,
    input  logic               ack_suppress,
    input  logic               clr_valid,
    input  logic [1:0]         clr_type,
    input  logic               clr_flash,
    output logic [1:0]         type_q,
    output logic               flash_q,
    output logic               src_q,
    output logic [AW-1:0]      addr_q,
    output logic               ack_q,
    output logic               any_err
);
    logic [1:0] type_nxt;
    logic       flash_nxt;
    logic       evt;

    // Next flag values: clear by mask first, then OR in new detections.
    always_comb begin
        type_nxt  = (type_q & ~(clr_valid ? clr_type : 2'b00)) | {hits.ext_ctl, hits.ia_wr};
        flash_nxt = (flash_q & ~(clr_valid && clr_flash)) | hits.flash_wr;
        evt       = hits.ia_wr || hits.ext_ctl || hits.flash_wr;
        any_err   = (|type_q) || flash_q;
    end

    // Flag, marker, address and acknowledge registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            type_q  <= '0;
            flash_q <= 1'b0;
            src_q   <= 1'b1;
            addr_q  <= '0;
            ack_q   <= 1'b0;
        end else begin
            type_q  <= type_nxt;
            flash_q <= flash_nxt;
            ack_q   <= evt && !ack_suppress;
            if (evt)
                src_q <= 1'b0;
            else if (type_nxt == 2'b00 && !flash_nxt)
                src_q <= 1'b1;
            if (evt && !any_err)
                addr_q <= addr;
        end
    end

    // R8
    ack_after_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_q |-> $past(evt && !ack_suppress));

    // R5
    flash_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_q && !(clr_valid && clr_flash)) |=> flash_q);

    // R7
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_err |=> $stable(addr_q));

    // R6
    src_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !src_q);
endmodule

// File: rtl/cpu_bus_err_chk.sv
// Module: cpu_bus_err_chk
// Top level of the processor bus error checker. It joins the transaction
// decoder and the error registers, packs the register images and forwards the
// non-maskable interrupt to the machine-check output. Any pending flag masks
// that output. Assumes one transaction per cycle, each qualified by txn_valid.
module cpu_bus_err_chk #(
    parameter logic [31:0] IA0_BASE = 32'hBFFF_FFF0,
    parameter logic [31:0] IA0_MASK = 32'hFFFF_FFF0,
    parameter logic [31:0] IA1_BASE = 32'hFEF0_0000,
    parameter logic [31:0] IA1_MASK = 32'hFFF0_0000,
    parameter logic [31:0] ROM_BASE = 32'hFFF0_0000,
    parameter logic [31:0] ROM_MASK = 32'hFFF0_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        txn_valid,
    input  logic [31:0] txn_addr,
    input  logic        txn_write,
    input  logic        txn_ext_ctl,
    input  logic        map_sel,
    input  logic        flash_wr_en,
    input  logic        flash_wr_lock,
    input  logic        ack_suppress,
    input  logic        clr_valid,
    input  logic [1:0]  clr_type,
    input  logic        clr_flash,
    input  logic        nmi_in,
    input  logic        mcp_en,
    output logic [7:0]  err1,
    output logic [7:0]  err2,
    output logic [31:0] err_addr,
    output logic        int_ack,
    output logic        mcp_out
);
    localparam int AW = cbe_pkg::ADDR_W;
    localparam int RW = cbe_pkg::REG_W;

    cbe_pkg::cbe_hits_t hits;
    logic [1:0]    type_q;
    logic          flash_q, src_q, any_err;
    logic [AW-1:0] addr_q;

    cbe_decode #(
        .AW(AW), .IA0_BASE(IA0_BASE), .IA0_MASK(IA0_MASK),
        .IA1_BASE(IA1_BASE), .IA1_MASK(IA1_MASK),
        .ROM_BASE(ROM_BASE), .ROM_MASK(ROM_MASK)
    ) u_dec (
        .valid(txn_valid), .addr(txn_addr), .write(txn_write),
        .ext_ctl(txn_ext_ctl), .map_sel(map_sel),
        .wr_en(flash_wr_en), .wr_lock(flash_wr_lock), .hits(hits)
    );

    cbe_err_regs #(.AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .hits(hits), .addr(txn_addr),
        .ack_suppress(ack_suppress), .clr_valid(clr_valid),
        .clr_type(clr_type), .clr_flash(clr_flash),
        .type_q(type_q), .flash_q(flash_q), .src_q(src_q),
        .addr_q(addr_q), .ack_q(int_ack), .any_err(any_err)
    );

    // Register images and machine-check forwarding.
    always_comb begin
        err1       = '0;
        err1[1:0]  = type_q;
        err1[3]    = src_q;
        err2       = '0;
        err2[0]    = flash_q;
        err2[RW-1] = src_q;
        err_addr   = addr_q;
        mcp_out    = nmi_in && mcp_en && !any_err;
    end
endmodule

// File: tb/sim_cpu_bus_err_chk.sv
`timescale 1ns/1ps
module sim_cpu_bus_err_chk;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic txn_valid = 0, txn_write = 0, txn_ext_ctl = 0, map_sel = 0;
    logic [31:0] txn_addr = '0;
    logic flash_wr_en = 0, flash_wr_lock = 0, ack_suppress = 0;
    logic clr_valid = 0, clr_flash = 0, nmi_in = 0, mcp_en = 0;
    logic [1:0] clr_type = '0;
    logic [7:0] err1, err2;
    logic [31:0] err_addr;
    logic int_ack, mcp_out;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    cpu_bus_err_chk u0 (
        .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_addr(txn_addr),
        .txn_write(txn_write), .txn_ext_ctl(txn_ext_ctl), .map_sel(map_sel),
        .flash_wr_en(flash_wr_en), .flash_wr_lock(flash_wr_lock),
        .ack_suppress(ack_suppress), .clr_valid(clr_valid), .clr_type(clr_type),
        .clr_flash(clr_flash), .nmi_in(nmi_in), .mcp_en(mcp_en),
        .err1(err1), .err2(err2), .err_addr(err_addr),
        .int_ack(int_ack), .mcp_out(mcp_out)
    );

    // Behavioural reference model state.
    bit [1:0]  m_type;
    bit        m_flash, m_src, m_ack;
    bit [31:0] m_addr;

    always @(posedge clk) begin
        bit ia, ext, fe, evt, pend;
        bit [1:0] nt;
        bit nf;
        if (!rst_n) begin
            m_type = 0; m_flash = 0; m_src = 1; m_addr = 0; m_ack = 0;
        end else begin
            ia  = txn_valid && txn_write &&
                  (map_sel ? (txn_addr >= 32'hFEF0_0000 && txn_addr <= 32'hFEFF_FFFF)
                           : (txn_addr >= 32'hBFFF_FFF0));
            if (!map_sel && txn_addr > 32'hBFFF_FFFF) ia = 0;
            ext = txn_valid && txn_ext_ctl;
            fe  = txn_valid && txn_write && txn_addr >= 32'hFFF0_0000 &&
                  !(flash_wr_en && !flash_wr_lock);
            evt  = ia || ext || fe;
            pend = (m_type != 0) || m_flash;
            nt = m_type;
            nf = m_flash;
            if (clr_valid) begin
                nt = nt & ~clr_type;
                if (clr_flash) nf = 0;
            end
            if (ia)  nt[0] = 1;
            if (ext) nt[1] = 1;
            if (fe)  nf = 1;
            if (evt && !pend) m_addr = txn_addr;
            if (evt) m_src = 0;
            else if (nt == 0 && !nf) m_src = 1;
            m_ack = evt && !ack_suppress;
            m_type = nt;
            m_flash = nf;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare every output against the model (called away from the edge).
    task automatic compare_all();
        chk("R1/R2/R3/R5", "err1 type", {30'b0, err1[1:0]}, {30'b0, m_type});
        chk("R6", "err1 marker/zeros", {24'b0, err1[7:2]}, {24'b0, 4'b0, m_src, 1'b0});
        chk("R4/R5", "err2 flash", {31'b0, err2[0]}, {31'b0, m_flash});
        chk("R6", "err2 marker/zeros", {25'b0, err2[7:1]}, {25'b0, m_src, 6'b0});
        chk("R7", "err_addr", err_addr, m_addr);
        chk("R8", "int_ack", {31'b0, int_ack}, {31'b0, m_ack});
        chk("R9", "mcp_out", {31'b0, mcp_out},
            {31'b0, nmi_in && mcp_en && m_type == 0 && !m_flash});
    endtask

    task automatic idle();
        txn_valid = 0; txn_write = 0; txn_ext_ctl = 0; clr_valid = 0;
        clr_type = 0; clr_flash = 0;
    endtask

    // One cycle: drive at negedge, let the edge pass, compare at the next negedge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
        idle();
    endtask

    task automatic txn(input logic [31:0] a, input logic wr, input logic ext);
        txn_valid = 1; txn_addr = a; txn_write = wr; txn_ext_ctl = ext;
        step();
    endtask

    task automatic clear_all();
        clr_valid = 1; clr_type = 2'b11; clr_flash = 1;
        step();
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", "reset err1", {24'b0, err1}, 32'h08);
        chk("R10", "reset err2", {24'b0, err2}, 32'h80);
        chk("R10", "reset err_addr", err_addr, 32'h0);
        chk("R10", "reset int_ack", {31'b0, int_ack}, 32'h0);
        rst_n = 1;
        step();

        // R10: an idle transaction strobe low has no effect
        txn_addr = 32'hBFFF_FFF4; txn_write = 1; step();
        chk("R10", "no valid, no flag", {24'b0, err1}, 32'h08);

        // R1: map 0 interrupt-acknowledge write, both edges of range
        map_sel = 0;
        txn(32'hBFFF_FFF0, 1, 0);
        chk("R1", "ia low edge", {30'b0, err1[1:0]}, 32'h1);
        chk("R8", "ack pulse", {31'b0, int_ack}, 32'h1);
        step();
        chk("R8", "ack one cycle", {31'b0, int_ack}, 32'h0);
        txn(32'hBFFF_FFFF, 1, 0);
        chk("R7", "first address held", err_addr, 32'hBFFF_FFF0);
        clear_all();
        chk("R6", "marker back", {31'b0, err1[3]}, 32'h1);
        txn(32'hBFFF_FFEF, 1, 0);   // just below window
        txn(32'hBFFF_FFF8, 0, 0);   // read
        txn(32'hFEF1_0000, 1, 0);   // other map's range
        chk("R1", "no flag outside", {30'b0, err1[1:0]}, 32'h0);

        // R2: map 1
        map_sel = 1;
        txn(32'hBFFF_FFF4, 1, 0);
        txn(32'hFEEF_FFFF, 1, 0);
        txn(32'hFEF5_0000, 0, 0);
        chk("R2", "no flag", {30'b0, err1[1:0]}, 32'h0);
        txn(32'hFEFF_FFFF, 1, 0);
        chk("R2", "ia map1", {30'b0, err1[1:0]}, 32'h1);
        clear_all();

        // R3: external-control transfers, read and write
        txn(32'h0000_1000, 0, 1);
        chk("R3", "ext read", {30'b0, err1[1:0]}, 32'h2);
        clr_valid = 1; clr_type = 2'b10; step();
        txn(32'h0000_2000, 1, 1);
        chk("R3", "ext write", {30'b0, err1[1:0]}, 32'h2);
        clear_all();

        // R4: Flash policy combinations
        for (int k = 0; k < 4; k++) begin
            flash_wr_en = k[0]; flash_wr_lock = k[1];
            txn(32'hFFF8_0000, 0, 0);
            txn(32'hFFF8_0000, 1, 0);
            chk("R4", "flash policy", {31'b0, err2[0]}, {31'b0, !(k == 1)});
            clear_all();
        end

        // R5: detection wins over a same-cycle clear; R8: suppression
        flash_wr_en = 0; ack_suppress = 1;
        txn(32'hFFFF_0000, 1, 0);
        chk("R8", "suppressed", {31'b0, int_ack}, 32'h0);
        clr_valid = 1; clr_flash = 1; txn(32'hFFFF_0004, 1, 0);
        chk("R5", "detect beats clear", {31'b0, err2[0]}, 32'h1);
        ack_suppress = 0;

        // R9: machine check masked while pending, NMI not recorded
        nmi_in = 1; mcp_en = 1; step();
        chk("R9", "masked", {31'b0, mcp_out}, 32'h0);
        clear_all();
        chk("R9", "forwarded", {31'b0, mcp_out}, 32'h1);
        chk("R9", "nmi not recorded", {24'b0, err1}, 32'h08);
        mcp_en = 0; step();
        chk("R9", "disabled", {31'b0, mcp_out}, 32'h0);

        // Mixed traffic scored against the model every cycle
        for (int n = 0; n < 3000; n++) begin
            int sel;
            sel = $urandom_range(0, 5);
            case (sel)
                0: txn_addr = 32'hBFFF_FFF0 | $urandom_range(0, 31);
                1: txn_addr = 32'hFEF0_0000 | ($urandom & 32'h001F_FFFF);
                2: txn_addr = 32'hFFF0_0000 | ($urandom & 32'h000F_FFFF);
                default: txn_addr = $urandom;
            endcase
            txn_valid = $urandom_range(0, 3) != 0;
            txn_write = $urandom_range(0, 1);
            txn_ext_ctl = $urandom_range(0, 9) == 0;
            map_sel = $urandom_range(0, 1);
            flash_wr_en = $urandom_range(0, 1);
            flash_wr_lock = $urandom_range(0, 1);
            ack_suppress = $urandom_range(0, 3) == 0;
            clr_valid = $urandom_range(0, 3) == 0;
            clr_type = 2'($urandom_range(0, 3));
            clr_flash = $urandom_range(0, 1);
            nmi_in = $urandom_range(0, 1);
            mcp_en = $urandom_range(0, 1);
            step();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule